// File: doc/BRIEF.md
# USB Receive Endpoint Control

This block is the receive-side control of a single USB device endpoint. It holds four things: the endpoint kind, a stall flag, a toggle-check inhibit flag and the data toggle the endpoint expects next. For every packet event from the protocol engine it decides three things: whether the endpoint answers with ACK, answers with STALL or stays silent, whether the payload is passed on to the memory path, and how the expected toggle moves.

Software configures the endpoint through an 8-bit write port and reads it back on a status bus. The protocol engine reports SETUP tokens, data packets with their DATA0/DATA1 identity, and whether the CRC was good. A SETUP updates the stall flag by itself. Control endpoints clear it. All other kinds set it, so a stray SETUP to a bulk or interrupt endpoint leaves that endpoint stalled until software clears it. The decision appears on the outputs one clock after the event.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x00 (control kind, not stalled, inhibit clear, expected toggle DATA0). `hs_code` reads 00 (none) and `data_accept` reads 0.
- R2: The configuration byte has these fields: bit 0 is stall, bits 2:1 are the kind (00 control, 01 isochronous, 10 bulk, 11 interrupt), bit 5 is toggle inhibit and bit 6 is toggle reset. Bits 3 (sink select) and 4 (reserved) are discarded. Bits 3, 4 and 6 always read 0, and bit 7 reads the expected toggle (1 = DATA1).
- R3: A SETUP with a good CRC on a control endpoint clears the stall flag and sets the expected toggle to DATA1. On any other kind it sets the stall flag and leaves the toggle alone. A SETUP itself produces no handshake (`hs_code` 00) and no accept.
- R4: While the stall flag is set, each good-CRC data packet to a non-isochronous endpoint gives `hs_code` 10 (STALL) with no accept. This repeats until software writes bit 0 to zero or a SETUP on a control endpoint clears the flag.
- R5: On a non-stalled, non-isochronous endpoint with inhibit clear, a good-CRC data packet whose PID equals the expected toggle gives `hs_code` 01 (ACK) and a one-cycle `data_accept` pulse, and it flips the expected toggle.
- R6: Under the conditions of R5, a data packet whose PID differs from the expected toggle gives ACK, no accept, and no change to the toggle.
- R7: A write with bit 6 set puts the expected toggle back to DATA0.
- R8: With inhibit set, a good-CRC data packet on a non-stalled, non-isochronous endpoint gives ACK and accept for either PID, and the toggle is left unchanged.
- R9: An isochronous endpoint never handshakes (`hs_code` 00). It accepts every good-CRC data packet whatever its PID when not stalled, and discards it silently when stalled. Its toggle never changes.
- R10: An event with a bad CRC gives no handshake and no accept, and changes no state.
- R11: When a configuration write and a packet event fall in the same cycle, the packet is judged on the state before the write. The written stall value, and a written toggle reset, take precedence over the changes the packet would make.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration byte written |
| cfg_rd_data | output | 8 | Configuration and toggle read-back |
| pkt_setup | input | 1 | SETUP token received this cycle |
| pkt_data | input | 1 | Data packet received this cycle |
| pkt_pid1 | input | 1 | Data packet is DATA1 (0 = DATA0) |
| pkt_crc_ok | input | 1 | CRC of the current event was good |
| hs_code | output | 2 | Handshake: 00 none, 01 ACK, 10 STALL |
| data_accept | output | 1 | Payload delivered to the memory path |

## Verification
A software write and a packet event can land in the same cycle. Both then want to change the stall flag and the expected toggle. The bench provokes this twice. In the first case, a write that sets the stall flag and resets the toggle arrives with a matching data packet. In the second, a write that clears the stall flag arrives with a SETUP on a bulk endpoint. In each case the bench judges the handshake against the state before the write, and the read-back afterwards against the written values.

// File: rtl/usb_rx_ep_pkg.sv
// Shared types and bit positions for the receive endpoint control.
// Assumes a configuration byte of at least 8 bits.
package usb_rx_ep_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    localparam int BIT_STALL = 0;
    localparam int BIT_KIND  = 1;
    localparam int KIND_W    = 2;
    localparam int BIT_INH   = 5;
    localparam int BIT_TRES  = 6;
    localparam int BIT_TOG   = 7;

    typedef struct packed {
        logic setup;
        logic data;
        logic pid1;
        logic crc_ok;
    } pkt_ev_t;

endpackage

// File: rtl/usb_rx_ep_regs.sv
// Holds the endpoint kind, stall flag and toggle inhibit flag.
// A software write takes precedence over the automatic stall update done on SETUP.
module usb_rx_ep_regs
    import usb_rx_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_stall,
    input  ep_kind_e wr_kind,
    input  logic     wr_inh,
    input  logic     setup_ok,
    output logic     stall,
    output ep_kind_e kind,
    output logic     inh
);

    // Configuration state: write wins, otherwise SETUP sets or clears stall by kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall <= 1'b0;
            kind  <= EP_CTRL;
            inh   <= 1'b0;
        end else if (wr_en) begin
            stall <= wr_stall;
            kind  <= wr_kind;
            inh   <= wr_inh;
        end else if (setup_ok) begin
            stall <= (kind != EP_CTRL);
        end
    end

endmodule

// File: rtl/usb_rx_ep_toggle.sv
// Tracks the data toggle expected next (1 = DATA1).
// Priority: a software reset, then SETUP on a control endpoint, then a flip on good data.
module usb_rx_ep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_reset,
    input  logic setup_ctrl,
    input  logic flip,
    output logic exp_tog
);

    // Expected toggle register with its priority chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_tog <= 1'b0;
        end else if (wr_reset) begin
            exp_tog <= 1'b0;
        end else if (setup_ctrl) begin
            exp_tog <= 1'b1;
        end else if (flip) begin
            exp_tog <= ~exp_tog;
        end
    end

endmodule

// File: rtl/usb_rx_ep_decide.sv
// Judges one packet event against the current endpoint state.
// Produces the handshake and the accept strobe one cycle later, and a
// combinational flip request for the toggle tracker.
// Assumes SETUP and data never coincide; if they do, the data packet is dropped.
module usb_rx_ep_decide
    import usb_rx_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pkt_ev_t  ev,
    input  logic     stall,
    input  ep_kind_e kind,
    input  logic     inh,
    input  logic     exp_tog,
    output logic     flip,
    output hs_e      hs_q,
    output logic     acc_q
);

    hs_e  hs_n;
    logic acc_n;
    logic data_ok;

    assign data_ok = ev.data && ev.crc_ok && !ev.setup;

    // Decision for the current event: kind, stall, inhibit and PID match.
    always_comb begin
        hs_n  = HS_NONE;
        acc_n = 1'b0;
        flip  = 1'b0;
        if (data_ok) begin
            if (kind == EP_ISO) begin
                acc_n = !stall;
            end else if (stall) begin
                hs_n = HS_STALL;
            end else if (inh) begin
                hs_n  = HS_ACK;
                acc_n = 1'b1;
            end else begin
                hs_n  = HS_ACK;
                acc_n = (ev.pid1 == exp_tog);
                flip  = (ev.pid1 == exp_tog);
            end
        end
    end

    // Output register for the handshake and the accept strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= HS_NONE;
            acc_q <= 1'b0;
        end else begin
            hs_q  <= hs_n;
            acc_q <= acc_n;
        end
    end

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
// Receive endpoint control top. It decodes the configuration byte, wires the
// state holders to the packet judge and builds the read-back byte.
// Assumes CFG_W >= 8. Bits above the defined fields read as zero.
module usb_rx_ep_ctrl
    import usb_rx_ep_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    input  logic             pkt_setup,
    input  logic             pkt_data,
    input  logic             pkt_pid1,
    input  logic             pkt_crc_ok,
    output logic [1:0]       hs_code,
    output logic             data_accept
);

    pkt_ev_t  ev;
    ep_kind_e kind;
    ep_kind_e wr_kind;
    logic     stall;
    logic     inh;
    logic     exp_tog;
    logic     flip;
    logic     setup_ok;
    hs_e      hs_q;
    logic     unused_cfg_bits;

    assign ev       = '{setup: pkt_setup, data: pkt_data, pid1: pkt_pid1, crc_ok: pkt_crc_ok};
    assign setup_ok = pkt_setup && pkt_crc_ok;
    assign wr_kind  = ep_kind_e'(cfg_wr_data[BIT_KIND +: KIND_W]);
    assign unused_cfg_bits = ^{cfg_wr_data[4:3], cfg_wr_data[CFG_W-1:BIT_TOG]};

    usb_rx_ep_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_stall (cfg_wr_data[BIT_STALL]),
        .wr_kind  (wr_kind),
        .wr_inh   (cfg_wr_data[BIT_INH]),
        .setup_ok (setup_ok),
        .stall    (stall),
        .kind     (kind),
        .inh      (inh)
    );

    usb_rx_ep_toggle u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_reset   (cfg_wr_en && cfg_wr_data[BIT_TRES]),
        .setup_ctrl (setup_ok && (kind == EP_CTRL)),
        .flip       (flip),
        .exp_tog    (exp_tog)
    );

    usb_rx_ep_decide u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .stall   (stall),
        .kind    (kind),
        .inh     (inh),
        .exp_tog (exp_tog),
        .flip    (flip),
        .hs_q    (hs_q),
        .acc_q   (data_accept)
    );

    assign hs_code = hs_q;

    // Read-back byte: the stored fields, plus the toggle in bit 7; all other bits are zero.
    always_comb begin
        cfg_rd_data                       = '0;
        cfg_rd_data[BIT_STALL]            = stall;
        cfg_rd_data[BIT_KIND +: KIND_W]   = kind;
        cfg_rd_data[BIT_INH]              = inh;
        cfg_rd_data[BIT_TOG]              = exp_tog;
    end

endmodule

// File: rtl/usb_rx_ep_ctrl_chk.sv
// Assertion checker for usb_rx_ep_ctrl, attached by bind below.
// It only observes the top-level ports.
module usb_rx_ep_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_en,
    input logic [7:0] cfg_rd_data,
    input logic       pkt_setup,
    input logic       pkt_data,
    input logic       pkt_pid1,
    input logic       pkt_crc_ok,
    input logic [1:0] hs_code,
    input logic       data_accept
);

    // R1: no event means quiet outputs next cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_data && !pkt_setup) |=> (hs_code == 2'b00 && !data_accept));

    // R3: SETUP on a non-control endpoint sets stall
    p_setup_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_setup && pkt_crc_ok && !cfg_wr_en && cfg_rd_data[2:1] != 2'b00)
        |=> (cfg_rd_data[0] && hs_code == 2'b00));

    // R4: a stalled non-isochronous endpoint answers STALL
    p_stall_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_data && !pkt_setup && pkt_crc_ok && cfg_rd_data[0] && cfg_rd_data[2:1] != 2'b01)
        |=> (hs_code == 2'b10 && !data_accept));

    // R5: a matching PID is accepted and flips the toggle
    p_match_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_data && !pkt_setup && pkt_crc_ok && !cfg_wr_en && !cfg_rd_data[0]
         && cfg_rd_data[2:1] != 2'b01 && !cfg_rd_data[5] && pkt_pid1 == cfg_rd_data[7])
        |=> (hs_code == 2'b01 && data_accept && cfg_rd_data[7] != $past(cfg_rd_data[7])));

    // R9: isochronous endpoints never handshake
    p_iso_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_data && cfg_rd_data[2:1] == 2'b01) |=> (hs_code == 2'b00));

    // R10: a bad CRC changes nothing and answers nothing
    p_crc_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_data || pkt_setup) && !pkt_crc_ok && !cfg_wr_en)
        |=> (hs_code == 2'b00 && !data_accept && $stable(cfg_rd_data)));

endmodule

bind usb_rx_ep_ctrl usb_rx_ep_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data[7:0]),
    .pkt_setup   (pkt_setup),
    .pkt_data    (pkt_data),
    .pkt_pid1    (pkt_pid1),
    .pkt_crc_ok  (pkt_crc_ok),
    .hs_code     (hs_code),
    .data_accept (data_accept)
);

// File: tb/usb_rx_ep_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver tasks update a behavioural model and queue the
// expected outputs. The monitor compares them on the falling edge after the
// cycle that registers them.
module usb_rx_ep_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       pkt_setup = 1'b0;
    logic       pkt_data = 1'b0;
    logic       pkt_pid1 = 1'b0;
    logic       pkt_crc_ok = 1'b0;
    logic [1:0] hs_code;
    logic       data_accept;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int        due;
        logic [1:0] hs;
        logic      acc;
        string     req;
    } exp_t;
    exp_t sb_q[$];

    // Model state
    logic       m_stall = 1'b0;
    logic [1:0] m_kind = 2'b00;
    logic       m_inh = 1'b0;
    logic       m_tog = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    usb_rx_ep_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .pkt_setup   (pkt_setup),
        .pkt_data    (pkt_data),
        .pkt_pid1    (pkt_pid1),
        .pkt_crc_ok  (pkt_crc_ok),
        .hs_code     (hs_code),
        .data_accept (data_accept)
    );

    function automatic logic [7:0] model_rd();
        return {m_tog, 1'b0, m_inh, 2'b00, m_kind, m_stall};
    endfunction

    // Applies one cycle of stimulus, queues the expected outputs and updates the model.
    task automatic step(input bit wr, input logic [7:0] wd, input bit su, input bit dt,
                        input bit pid, input bit crc, input string req);
        exp_t e;
        @(negedge clk);
        cfg_wr_en = wr; cfg_wr_data = wd;
        pkt_setup = su; pkt_data = dt; pkt_pid1 = pid; pkt_crc_ok = crc;
        e.due = cyc + 1; e.hs = 2'b00; e.acc = 1'b0; e.req = req;
        if (dt && crc && !su) begin
            if (m_kind == 2'b01) e.acc = !m_stall;
            else if (m_stall) e.hs = 2'b10;
            else if (m_inh) begin e.hs = 2'b01; e.acc = 1'b1; end
            else begin
                e.hs = 2'b01;
                e.acc = (pid == m_tog);
                if (pid == m_tog) m_tog = ~m_tog;
            end
        end
        if (su && crc) begin
            if (m_kind == 2'b00) m_tog = 1'b1;
            m_stall = (m_kind != 2'b00);
        end
        if (wr) begin
            m_stall = wd[0]; m_kind = wd[2:1]; m_inh = wd[5];
            if (wd[6]) m_tog = 1'b0;
        end
        if (dt || su) sb_q.push_back(e);
        @(posedge clk); #1;
        cfg_wr_en = 1'b0; pkt_setup = 1'b0; pkt_data = 1'b0; pkt_pid1 = 1'b0; pkt_crc_ok = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] wd, input string req);
        step(1'b1, wd, 1'b0, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic data(input bit pid, input bit crc, input string req);
        step(1'b0, 8'h00, 1'b0, 1'b1, pid, crc, req);
    endtask

    task automatic setup(input bit crc, input string req);
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, crc, req);
    endtask

    // Compares the read-back byte with the model.
    task automatic chk_rd(input string req);
        @(negedge clk);
        checks++;
        if (cfg_rd_data !== model_rd()) begin
            errors++;
            $display("FAIL %s: cfg_rd_data actual %02h expected %02h", req, cfg_rd_data, model_rd());
        end
    endtask

    // Monitor: pops due items and compares; otherwise outputs must be quiet.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (hs_code !== e.hs || data_accept !== e.acc) begin
                    errors++;
                    $display("FAIL %s: hs/accept actual %b/%b expected %b/%b",
                             e.req, hs_code, data_accept, e.hs, e.acc);
                end
            end else if (hs_code !== 2'b00 || data_accept !== 1'b0) begin
                checks++; errors++;
                $display("FAIL R1: idle hs/accept actual %b/%b expected 00/0", hs_code, data_accept);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_rd("R1");
        // R1: outputs after reset
        @(negedge clk); checks++;
        if (hs_code !== 2'b00 || data_accept !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset hs/accept actual %b/%b expected 00/0", hs_code, data_accept);
        end
        // R2: field layout and bits that read zero
        wr_cfg(8'h04, "R2"); chk_rd("R2");
        wr_cfg(8'h5C, "R2"); chk_rd("R2");
        wr_cfg(8'h06, "R2"); chk_rd("R2");
        wr_cfg(8'h04, "R2");
        // R5 / R6: toggle sequencing on bulk
        data(1'b0, 1'b1, "R5"); chk_rd("R5");
        data(1'b0, 1'b1, "R6"); chk_rd("R6");
        data(1'b1, 1'b1, "R5"); chk_rd("R5");
        data(1'b0, 1'b1, "R5");
        // R7: toggle reset
        wr_cfg(8'h44, "R7"); chk_rd("R7");
        data(1'b1, 1'b1, "R7");
        data(1'b0, 1'b1, "R7");
        // R10: bad CRC on data and SETUP
        data(1'b1, 1'b0, "R10"); chk_rd("R10");
        setup(1'b0, "R10"); chk_rd("R10");
        // R3 / R4: SETUP stalls a bulk endpoint
        setup(1'b1, "R3"); chk_rd("R3");
        data(1'b0, 1'b1, "R4");
        data(1'b1, 1'b1, "R4");
        wr_cfg(8'h04, "R4");
        data(1'b0, 1'b1, "R4");
        wr_cfg(8'h05, "R4");
        data(1'b1, 1'b1, "R4");
        // R3: SETUP clears stall on control and sets DATA1 expected
        wr_cfg(8'h01, "R3");
        data(1'b0, 1'b1, "R4");
        setup(1'b1, "R3"); chk_rd("R3");
        data(1'b1, 1'b1, "R3"); chk_rd("R3");
        // R8: inhibit accepts both PIDs without moving the toggle
        wr_cfg(8'h24, "R8");
        data(1'b1, 1'b1, "R8");
        data(1'b0, 1'b1, "R8"); chk_rd("R8");
        // R9: isochronous endpoint
        wr_cfg(8'h02, "R9");
        data(1'b1, 1'b1, "R9");
        data(1'b0, 1'b1, "R9"); chk_rd("R9");
        wr_cfg(8'h03, "R9");
        data(1'b0, 1'b1, "R9");
        // R11: write concurrent with a matching data packet
        wr_cfg(8'h44, "R11");
        step(1'b1, 8'h45, 1'b0, 1'b1, 1'b0, 1'b1, "R11"); chk_rd("R11");
        data(1'b0, 1'b1, "R11");
        // R11: write clearing stall concurrent with SETUP on bulk
        wr_cfg(8'h04, "R11");
        step(1'b1, 8'h04, 1'b1, 1'b0, 1'b0, 1'b1, "R11"); chk_rd("R11");
        data(1'b0, 1'b1, "R11");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule